// File: doc/BRIEF.md
# Deferred Miss-Slice Replay Buffer

The block holds, in program order, instructions that a pipeline set aside because they depend on a cache miss that has not returned. Each slot keeps the decoded instruction word, its sequence number, the one source operand that did not depend on a miss, and an 8-bit poison vector. Each poison bit stands for one group of outstanding misses. When a miss returns, the pipeline presents the returned bits on a wake mask. The block then makes a replay pass: it walks the slots from the oldest live one up to the tail as it stood when the pass began. It issues, at most one per cycle, every slot whose poison vector shares a bit with the mask.

Each issued slot goes to execute together with its slot index. Execute answers on the feedback port, giving the same index. It either completes the slot, which clears it, or re-poisons it in place with a new vector. Slots are never moved or appended again, so the storage thins out over successive passes. Space is freed only by moving the head past slots that are cleared. A full flag tells the pipeline to stop deferring. An empty flag tells it that no deferred work is left.

Top module: `miss_slice_buffer`

## Requirements
- R1: After reset, empty_o is 1, full_o is 0 and iss_valid_o is 0.
- R2: A pass issues at most one slot per cycle and issues slots in ascending program order from head toward tail. Each issue carries the slot index on iss_idx_o, which equals the slot's order of enqueue modulo 128, and the instruction word and sequence number written at enqueue.
- R3: iss_opnd_o carries, unchanged, the operand value captured at enqueue.
- R4: A pass started by wake mask M issues exactly the slots whose poison vector ANDed with M is non-zero. Slots whose vector has only bits outside M are skipped.
- R5: Feedback with fb_repoison_i=1 replaces the poison vector of slot fb_idx_i with fb_poison_i, in the same slot. Feedback with fb_repoison_i=0 clears the slot. A re-poisoned slot is issued again, with its original index and ahead of younger slots, by a later pass whose mask shares one of its bits.
- R6: A pass covers only slots enqueued before the pass starts. Slots enqueued while it runs are left for later passes.
- R7: Wake bits that arrive while a pass is running are collected. A further pass with those bits starts after the running pass ends.
- R8: full_o is 1 exactly when 128 slots lie between head and tail. An enqueue while full_o is 1 is dropped.
- R9: Storage is reclaimed only at the head, one slot per cycle, past slots that are cleared and not awaiting feedback. A cleared slot behind a live head frees nothing. empty_o is 1 when the head reaches the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | 1 | Defer one instruction this cycle |
| enq_insn_i | input | 32 | Decoded instruction word |
| enq_seq_i | input | 16 | Sequence number of the instruction |
| enq_opnd_i | input | 32 | Captured miss-independent operand |
| enq_poison_i | input | 8 | Poison vector; all-zero means the slot is cleared at once |
| full_o | output | 1 | All 128 slots are held |
| empty_o | output | 1 | Head equals tail |
| wake_i | input | 8 | Poison bits whose misses returned this cycle |
| iss_valid_o | output | 1 | Replay issue valid |
| iss_idx_o | output | 7 | Slot index of the issued entry |
| iss_insn_o | output | 32 | Instruction word of the issued entry |
| iss_seq_o | output | 16 | Sequence number of the issued entry |
| iss_opnd_o | output | 32 | Captured operand of the issued entry |
| fb_valid_i | input | 1 | Feedback for one issued slot |
| fb_idx_i | input | 7 | Slot being resolved |
| fb_repoison_i | input | 1 | 1 to re-poison the slot, 0 to complete it |
| fb_poison_i | input | 8 | New poison vector when re-poisoning |

## Verification
The hardest situation to reach from the ports is a full buffer whose oldest slot stays live while every younger slot has been cleared. In that state full_o must stay high, because nothing is compacted. The bench fills all 128 slots, giving the first slot one poison bit and the rest another. It replays only the second bit, and checks that full_o holds until a second wake clears the head. Two further directed sequences cover the other hard cases. One pulses a second wake bit during a running pass. The other enqueues behind a pass that has already captured its tail. Random passes with mixed completion and re-poisoning exercise slots that thin out over many passes.

// File: rtl/slb_pkg.sv
`timescale 1ns/1ps
package slb_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;
endpackage

// File: rtl/slb_store.sv
`timescale 1ns/1ps
module slb_store #(
  parameter int DEPTH = 128,
  parameter int PW    = 8,
  parameter int IW    = 32,
  parameter int SW    = 16,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [IW-1:0]    wr_insn_i,
  input  logic [SW-1:0]    wr_seq_i,
  input  logic [DW-1:0]    wr_opnd_i,
  input  logic [PW-1:0]    wr_poison_i,
  input  logic             clr_en_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  input  logic             fb_en_i,
  input  logic [IDX_W-1:0] fb_idx_i,
  input  logic             fb_repoison_i,
  input  logic [PW-1:0]    fb_poison_i,
  input  logic [IDX_W-1:0] ra_idx_i,
  output logic [IW-1:0]    ra_insn_o,
  output logic [SW-1:0]    ra_seq_o,
  output logic [DW-1:0]    ra_opnd_o,
  output logic [PW-1:0]    ra_poison_o,
  input  logic [IDX_W-1:0] rb_idx_i,
  output logic [PW-1:0]    rb_poison_o,
  output logic             rb_pend_o
);
  logic [IW-1:0] insn_q   [DEPTH];
  logic [SW-1:0] seq_q    [DEPTH];
  logic [DW-1:0] opnd_q   [DEPTH];
  logic [PW-1:0] poison_q [DEPTH];
  logic          pend_q   [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      insn_q[wr_idx_i] <= wr_insn_i;
      seq_q[wr_idx_i]  <= wr_seq_i;
      opnd_q[wr_idx_i] <= wr_opnd_i;
    end
  end

  // pend: issued, waiting for feedback; poison already cleared
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        poison_q[i] <= '0;
        pend_q[i]   <= 1'b0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_en_i && wr_idx_i == IDX_W'(i)) begin
          poison_q[i] <= wr_poison_i;
          pend_q[i]   <= 1'b0;
        end else if (clr_en_i && clr_idx_i == IDX_W'(i)) begin
          poison_q[i] <= '0;
          pend_q[i]   <= 1'b1;
        end else if (fb_en_i && fb_idx_i == IDX_W'(i)) begin
          poison_q[i] <= fb_repoison_i ? fb_poison_i : '0;
          pend_q[i]   <= 1'b0;
        end
      end
    end
  end

  assign ra_insn_o   = insn_q[ra_idx_i];
  assign ra_seq_o    = seq_q[ra_idx_i];
  assign ra_opnd_o   = opnd_q[ra_idx_i];
  assign ra_poison_o = poison_q[ra_idx_i];
  assign rb_poison_o = poison_q[rb_idx_i];
  assign rb_pend_o   = pend_q[rb_idx_i];
endmodule

// File: rtl/slb_scan.sv
`timescale 1ns/1ps
module slb_scan import slb_pkg::*; #(
  parameter int PW    = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PW-1:0]    wake_i,
  input  logic [CNT_W-1:0] head_i,
  input  logic [CNT_W-1:0] tail_i,
  input  logic [PW-1:0]    slot_poison_i,
  output logic [CNT_W-1:0] ptr_o,
  output logic [CNT_W-1:0] end_o,
  output logic             active_o,
  output logic             start_o,
  output logic             hit_o
);
  scan_state_e   state_q;
  logic [PW-1:0] mask_q;
  logic [PW-1:0] queued_q;

  assign active_o = (state_q == SCAN_RUN);
  assign start_o  = (state_q == SCAN_IDLE) && |queued_q;
  assign hit_o    = active_o && (ptr_o != end_o) && |(slot_poison_i & mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SCAN_IDLE;
      ptr_o    <= '0;
      end_o    <= '0;
      mask_q   <= '0;
      queued_q <= '0;
    end else begin
      case (state_q)
        SCAN_IDLE: begin
          if (start_o) begin
            state_q  <= SCAN_RUN;
            ptr_o    <= head_i;
            end_o    <= tail_i;
            mask_q   <= queued_q;
            queued_q <= wake_i;
          end else begin
            queued_q <= queued_q | wake_i;
          end
        end
        default: begin
          queued_q <= queued_q | wake_i;
          if (ptr_o == end_o) state_q <= SCAN_IDLE;
          else                ptr_o   <= ptr_o + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/miss_slice_buffer.sv
`timescale 1ns/1ps
module miss_slice_buffer #(
  parameter int DEPTH = 128,
  parameter int PW    = 8,
  parameter int IW    = 32,
  parameter int SW    = 16,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enq_valid_i,
  input  logic [IW-1:0]    enq_insn_i,
  input  logic [SW-1:0]    enq_seq_i,
  input  logic [DW-1:0]    enq_opnd_i,
  input  logic [PW-1:0]    enq_poison_i,
  output logic             full_o,
  output logic             empty_o,
  input  logic [PW-1:0]    wake_i,
  output logic             iss_valid_o,
  output logic [IDX_W-1:0] iss_idx_o,
  output logic [IW-1:0]    iss_insn_o,
  output logic [SW-1:0]    iss_seq_o,
  output logic [DW-1:0]    iss_opnd_o,
  input  logic             fb_valid_i,
  input  logic [IDX_W-1:0] fb_idx_i,
  input  logic             fb_repoison_i,
  input  logic [PW-1:0]    fb_poison_i
);
  localparam int CNT_W = IDX_W + 1;

  logic [CNT_W-1:0] head_q, tail_q, count;
  logic [CNT_W-1:0] scan_ptr, scan_end;
  logic             scan_active, scan_start, scan_hit;
  logic             enq_ok, head_live, head_adv;
  logic [PW-1:0]    hd_poison, rd_poison;
  logic             hd_pend;
  logic [IW-1:0]    rd_insn;
  logic [SW-1:0]    rd_seq;
  logic [DW-1:0]    rd_opnd;

  assign count     = tail_q - head_q;
  assign full_o    = (count == CNT_W'(DEPTH));
  assign empty_o   = (head_q == tail_q);
  assign enq_ok    = enq_valid_i && !full_o;
  assign head_live = !empty_o && (|hd_poison || hd_pend);
  // head never overtakes the scan pointer, so a pass never reads a reused slot
  assign head_adv  = !empty_o && !head_live && !scan_start &&
                     !(scan_active && head_q == scan_ptr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (enq_ok)   tail_q <= tail_q + 1'b1;
      if (head_adv) head_q <= head_q + 1'b1;
    end
  end

  slb_store #(
    .DEPTH(DEPTH), .PW(PW), .IW(IW), .SW(SW), .DW(DW)
  ) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (enq_ok),
    .wr_idx_i     (tail_q[IDX_W-1:0]),
    .wr_insn_i    (enq_insn_i),
    .wr_seq_i     (enq_seq_i),
    .wr_opnd_i    (enq_opnd_i),
    .wr_poison_i  (enq_poison_i),
    .clr_en_i     (scan_hit),
    .clr_idx_i    (scan_ptr[IDX_W-1:0]),
    .fb_en_i      (fb_valid_i),
    .fb_idx_i     (fb_idx_i),
    .fb_repoison_i(fb_repoison_i),
    .fb_poison_i  (fb_poison_i),
    .ra_idx_i     (scan_ptr[IDX_W-1:0]),
    .ra_insn_o    (rd_insn),
    .ra_seq_o     (rd_seq),
    .ra_opnd_o    (rd_opnd),
    .ra_poison_o  (rd_poison),
    .rb_idx_i     (head_q[IDX_W-1:0]),
    .rb_poison_o  (hd_poison),
    .rb_pend_o    (hd_pend)
  );

  slb_scan #(.PW(PW), .CNT_W(CNT_W)) u_scan (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wake_i       (wake_i),
    .head_i       (head_q),
    .tail_i       (tail_q),
    .slot_poison_i(rd_poison),
    .ptr_o        (scan_ptr),
    .end_o        (scan_end),
    .active_o     (scan_active),
    .start_o      (scan_start),
    .hit_o        (scan_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iss_valid_o <= 1'b0;
      iss_idx_o   <= '0;
      iss_insn_o  <= '0;
      iss_seq_o   <= '0;
      iss_opnd_o  <= '0;
    end else begin
      iss_valid_o <= scan_hit;
      if (scan_hit) begin
        iss_idx_o  <= scan_ptr[IDX_W-1:0];
        iss_insn_o <= rd_insn;
        iss_seq_o  <= rd_seq;
        iss_opnd_o <= rd_opnd;
      end
    end
  end
endmodule

// File: rtl/slb_chk.sv
`timescale 1ns/1ps
module slb_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enq_valid_i,
  input logic             full_o,
  input logic             empty_o,
  input logic             iss_valid_o,
  input logic             head_live,
  input logic             scan_active,
  input logic [CNT_W-1:0] head_q,
  input logic [CNT_W-1:0] tail_q,
  input logic [CNT_W-1:0] scan_end
);
  a_r8_full_drops_enq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && enq_valid_i |=> $stable(tail_q));

  a_r9_live_head_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_live |=> $stable(head_q));

  a_r9_empty_persists: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && !enq_valid_i |=> empty_o);

  a_r6_pass_end_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_active && $past(scan_active) |-> $stable(scan_end));

  a_r2_issue_from_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o |-> $past(scan_active));
endmodule

bind miss_slice_buffer slb_chk #(.CNT_W(CNT_W)) u_slb_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enq_valid_i(enq_valid_i),
  .full_o     (full_o),
  .empty_o    (empty_o),
  .iss_valid_o(iss_valid_o),
  .head_live  (head_live),
  .scan_active(scan_active),
  .head_q     (head_q),
  .tail_q     (tail_q),
  .scan_end   (scan_end)
);

// File: tb/miss_slice_buffer_test.sv
`timescale 1ns/1ps
module miss_slice_buffer_test;
  localparam int DEPTH = 128;
  localparam int PW    = 8;
  localparam int IW    = 32;
  localparam int SW    = 16;
  localparam int DW    = 32;
  localparam int IDX_W = 7;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             enq_valid_i;
  logic [IW-1:0]    enq_insn_i;
  logic [SW-1:0]    enq_seq_i;
  logic [DW-1:0]    enq_opnd_i;
  logic [PW-1:0]    enq_poison_i;
  logic             full_o, empty_o;
  logic [PW-1:0]    wake_i;
  logic             iss_valid_o;
  logic [IDX_W-1:0] iss_idx_o;
  logic [IW-1:0]    iss_insn_o;
  logic [SW-1:0]    iss_seq_o;
  logic [DW-1:0]    iss_opnd_o;
  logic             fb_valid_i;
  logic [IDX_W-1:0] fb_idx_i;
  logic             fb_repoison_i;
  logic [PW-1:0]    fb_poison_i;

  miss_slice_buffer uut (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  string cur_req = "R2";
  int fb_mode = 1;  // 0 random, 1 complete, 2 re-poison with bit 1

  logic [PW-1:0] m_poison [DEPTH];
  logic [SW-1:0] m_seq    [DEPTH];
  logic [DW-1:0] m_opnd   [DEPTH];
  logic [IW-1:0] m_insn   [DEPTH];
  int m_head = 0;
  int m_tail = 0;
  int exp_q[$];
  logic [SW-1:0] seq_ctr = 16'h0100;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // issue monitor and feedback responder
  always @(negedge clk_i) begin : mon
    int slot;
    logic rp;
    logic [PW-1:0] np;
    if (rst_ni && iss_valid_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL %s unexpected issue actual=%0h expected=none", cur_req, iss_idx_o);
      end else begin
        slot = exp_q.pop_front();
        chk(cur_req, "issue idx", 64'(iss_idx_o), 64'(slot));
        chk(cur_req, "issue seq", 64'(iss_seq_o), 64'(m_seq[slot]));
        chk(cur_req, "issue insn", 64'(iss_insn_o), 64'(m_insn[slot]));
        chk("R3", "captured operand", 64'(iss_opnd_o), 64'(m_opnd[slot]));
      end
      case (fb_mode)
        0: begin rp = $urandom_range(0, 1) == 1; np = PW'($urandom_range(1, 255)); end
        2: begin rp = 1'b1; np = 8'h02; end
        default: begin rp = 1'b0; np = '0; end
      endcase
      fb_valid_i    = 1'b1;
      fb_idx_i      = iss_idx_o;
      fb_repoison_i = rp;
      fb_poison_i   = np;
      m_poison[iss_idx_o] = rp ? np : '0;
    end else begin
      fb_valid_i = 1'b0;
    end
  end

  task automatic enq(input logic [PW-1:0] p);
    int slot;
    @(negedge clk_i);
    enq_valid_i  = 1'b1;
    enq_insn_i   = $urandom;
    enq_seq_i    = seq_ctr;
    enq_opnd_i   = $urandom;
    enq_poison_i = p;
    if (m_tail - m_head < DEPTH) begin
      slot = m_tail % DEPTH;
      m_poison[slot] = p;
      m_seq[slot]    = seq_ctr;
      m_opnd[slot]   = enq_opnd_i;
      m_insn[slot]   = enq_insn_i;
      m_tail++;
    end
    seq_ctr++;
    @(negedge clk_i);
    enq_valid_i = 1'b0;
  endtask

  task automatic build_exp(input logic [PW-1:0] mask);
    for (int i = m_head; i < m_tail; i++)
      if ((m_poison[i % DEPTH] & mask) != 0) exp_q.push_back(i % DEPTH);
  endtask

  task automatic pulse_wake(input logic [PW-1:0] mask);
    @(negedge clk_i); wake_i = mask;
    @(negedge clk_i); wake_i = '0;
  endtask

  task automatic settle(input string req);
    repeat (2 * DEPTH + 20) @(negedge clk_i);
    chk(req, "issues still outstanding", 64'(exp_q.size()), 64'd0);
    exp_q.delete();
    while (m_head < m_tail && m_poison[m_head % DEPTH] == 0) m_head++;
  endtask

  task automatic check_flags(input string req);
    chk(req, "empty_o", 64'(empty_o), 64'(m_head == m_tail));
    chk("R8", "full_o", 64'(full_o), 64'((m_tail - m_head) == DEPTH));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [PW-1:0] mask;
    void'($urandom(32'h1d5e_ed01));
    rst_ni = 1'b0; enq_valid_i = 1'b0; enq_insn_i = '0; enq_seq_i = '0;
    enq_opnd_i = '0; enq_poison_i = '0; wake_i = '0;
    fb_valid_i = 1'b0; fb_idx_i = '0; fb_repoison_i = 1'b0; fb_poison_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1", "empty_o", 64'(empty_o), 64'd1);
    chk("R1", "full_o", 64'(full_o), 64'd0);
    chk("R1", "iss_valid_o", 64'(iss_valid_o), 64'd0);

    // R6: entry deferred after the pass captured its tail waits
    cur_req = "R6"; fb_mode = 1;
    enq(8'h01);
    build_exp(8'h01);
    pulse_wake(8'h01);
    enq(8'h01);
    settle("R6");
    chk("R6", "late entry still held, empty_o", 64'(empty_o), 64'd0);
    build_exp(8'h01);
    pulse_wake(8'h01);
    settle("R6");
    check_flags("R9");

    // R7: second wake during a running pass gets its own pass
    cur_req = "R7";
    enq(8'h01); enq(8'h04); enq(8'h01);
    build_exp(8'h01);
    build_exp(8'h04);
    @(negedge clk_i); wake_i = 8'h01;
    @(negedge clk_i); wake_i = 8'h04;
    @(negedge clk_i); wake_i = 8'h00;
    settle("R7");
    check_flags("R9");

    // R5: re-poison in place, reissued ahead of a younger entry
    cur_req = "R5"; fb_mode = 2;
    enq(8'h01);
    build_exp(8'h01);
    pulse_wake(8'h01);
    settle("R5");
    chk("R5", "re-poisoned slot kept, empty_o", 64'(empty_o), 64'd0);
    fb_mode = 1;
    enq(8'h02);
    build_exp(8'h02);
    pulse_wake(8'h02);
    settle("R5");
    check_flags("R9");

    // R2/R4: random passes with mixed completion and re-poisoning
    cur_req = "R2"; fb_mode = 0;
    for (int it = 0; it < 40; it++) begin
      int n;
      n = $urandom_range(0, 12);
      for (int j = 0; j < n; j++) begin
        if (m_tail - m_head < 100) begin
          if ($urandom_range(0, 2) == 0) enq(PW'($urandom_range(1, 255)));
          else                           enq(PW'(1 << $urandom_range(0, 7)));
        end
      end
      mask = PW'(1 << $urandom_range(0, 7));
      if ($urandom_range(0, 1) == 1) mask = mask | PW'(1 << $urandom_range(0, 7));
      build_exp(mask);
      pulse_wake(mask);
      settle("R4");
      check_flags("R9");
    end

    // drain everything
    cur_req = "R9"; fb_mode = 1;
    build_exp(8'hFF);
    pulse_wake(8'hFF);
    settle("R9");
    check_flags("R9");
    chk("R9", "drained empty_o", 64'(empty_o), 64'd1);

    // R8: fill all slots, live head with bit 7, rest with bit 0
    cur_req = "R8";
    enq(8'h80);
    for (int k = 0; k < DEPTH - 1; k++) enq(8'h01);
    chk("R8", "full_o after 128 enqueues", 64'(full_o), 64'd1);
    enq(8'h01);  // dropped
    chk("R8", "full_o after dropped enqueue", 64'(full_o), 64'd1);
    build_exp(8'h01);
    chk("R8", "expected issue count", 64'(exp_q.size()), 64'(DEPTH - 1));
    pulse_wake(8'h01);
    settle("R8");
    chk("R9", "live head keeps full_o", 64'(full_o), 64'd1);
    chk("R9", "live head keeps empty_o low", 64'(empty_o), 64'd0);
    cur_req = "R9";
    build_exp(8'h80);
    pulse_wake(8'h80);
    settle("R9");
    check_flags("R9");
    chk("R9", "empty_o after head cleared", 64'(empty_o), 64'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule